// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block sits between dispatch and the architectural state of an out-of-order core. Dispatch claims up to two slots per cycle in program order. The index of each claimed slot is handed back as the rename tag that dependent operations wait on. Execution units later write their result into the slot addressed by that tag. Each result may carry a mispredict mark (branches only) or an exception mark.

Results leave the buffer only from the oldest end, at most two per cycle, and strictly in program order. The type of each slot picks where a retiring result goes:

- a register write, with destination and value;
- a store release;
- a branch resolution.

A mispredicted branch or a faulting slot takes effect only once it is the oldest slot. It then discards every younger slot in the same cycle. Two lookup ports let dispatch read a pending operand's value and ready flag by tag.

Top module: `rob_commit_unit`

## Requirements
- R1: After reset the buffer is empty. No retire, flush or fault output is active, every lookup reports not ready, and a dispatch request of two is granted.
- R2: A dispatch request is granted as a whole when the number of requested slots is at most the number of free slots, and refused as a whole otherwise. Granted slots take consecutive tags from the tail, lower request lane first. Tags wrap modulo the depth.
- R3: A completion write to an occupied slot stores its value and sets the slot ready. A lookup port returns ready only for an occupied, completed slot, and then returns its stored value. Lookup shows the state at the start of the cycle.
- R4: Up to two slots retire per cycle, starting at the head and in program order. Retirement stops at the first slot that is not ready. A younger completed slot never retires before an older pending one.
- R5: The slot type encoding is 0 = register, 1 = store, 2 = branch. A retiring register slot raises `rf_we_o` with its destination and value. A store slot raises `st_rel_o` and a branch slot raises `br_res_o`. Each lane also reports its tag and value.
- R6: A ready branch at the head carrying the mispredict mark retires with `br_mis_o` and `br_res_o` on lane 0, and nothing else retires in that cycle. All other slots are discarded and no dispatch is granted in that cycle. The next allocation starts at the tag right after the branch.
- R7: A mispredicted branch that is ready but not at the head does not retire in lane 1 and does not flush. Older slots ahead of it still retire.
- R8: A ready slot at the head with the exception mark raises `exc_o` with its tag in `exc_tag_o`. It does not retire and does not write state. All slots are discarded, dispatch is refused in that cycle, and the next allocation reuses the faulting slot's tag.
- R9: A completion write addressed to a free or discarded slot is ignored: a later lookup of that tag reports not ready.
- R10: At the full boundary, with one free slot a request of two is refused and a request of one is granted. The occupancy never exceeds the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_req_i | input | 2 | Per-lane allocation request, lane 0 older |
| disp_kind_i | input | 4 | Per-lane slot type, 2 bits each |
| disp_dst_i | input | 10 | Per-lane destination register, 5 bits each |
| disp_ok_o | output | 1 | Whole request granted this cycle |
| disp_tag_o | output | 8 | Per-lane assigned tag, 4 bits each |
| cpl_vld_i | input | 2 | Per-port completion strobe |
| cpl_tag_i | input | 8 | Per-port completed tag |
| cpl_data_i | input | 64 | Per-port result value |
| cpl_mis_i | input | 2 | Per-port mispredict mark |
| cpl_exc_i | input | 2 | Per-port exception mark |
| look_tag_i | input | 8 | Per-port lookup tag |
| look_data_o | output | 64 | Per-port looked-up value |
| look_rdy_o | output | 2 | Per-port looked-up slot completed |
| rf_we_o | output | 2 | Per-lane register write |
| st_rel_o | output | 2 | Per-lane store release |
| br_res_o | output | 2 | Per-lane branch resolution |
| ret_tag_o | output | 8 | Per-lane retiring tag |
| ret_dst_o | output | 10 | Per-lane destination register |
| ret_data_o | output | 64 | Per-lane retiring value |
| br_mis_o | output | 1 | Mispredict flush this cycle |
| exc_o | output | 1 | Exception taken this cycle |
| exc_tag_o | output | 4 | Tag of the faulting slot |

## Verification
The bench builds the block with its defaults: 16 slots, two dispatch lanes, two completion ports, two retire lanes and two lookup ports. A 16-slot ring with two-wide allocation reaches the full and one-free boundaries in eight cycles. Random traffic wraps the pointers many times in a few thousand cycles. Two retire lanes are enough to place a mispredicted branch either at the head or directly behind a retiring slot. That covers both the flush path and the stop-before-branch path.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } kind_e;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 16,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] alloc_n_i,
  input  logic [CNT_W-1:0] ret_n_i,
  input  logic             mis_flush_i,
  input  logic             exc_flush_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (exc_flush_i) begin
      tail_q <= head_q;
      cnt_q  <= '0;
    end else if (mis_flush_i) begin
      head_q <= head_q + TAG_W'(1);
      tail_q <= head_q + TAG_W'(1);
      cnt_q  <= '0;
    end else begin
      head_q <= head_q + TAG_W'(ret_n_i);
      tail_q <= tail_q + TAG_W'(alloc_n_i);
      cnt_q  <= cnt_q + alloc_n_i - ret_n_i;
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign cnt_o  = cnt_q;

  // R10
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R2
  ptr_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_q == head_q + TAG_W'(cnt_q));

  // R6
  mis_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mis_flush_i && !exc_flush_i) |=> (cnt_q == '0) && (head_q == $past(head_q) + TAG_W'(1)));
endmodule

// File: rtl/rob_store.sv
module rob_store
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int DISP_N = 2,
  parameter int CPL_N  = 2,
  parameter int RET_N  = 2,
  parameter int LOOK_N = 2,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [DISP_N-1:0]                 alloc_we_i,
  input  logic [DISP_N-1:0][TAG_W-1:0]      alloc_idx_i,
  input  kind_e [DISP_N-1:0]                alloc_kind_i,
  input  logic [DISP_N-1:0][REG_AW-1:0]     alloc_dst_i,
  input  logic [CPL_N-1:0]                  cpl_vld_i,
  input  logic [CPL_N-1:0][TAG_W-1:0]       cpl_tag_i,
  input  logic [CPL_N-1:0][DATA_W-1:0]      cpl_data_i,
  input  logic [CPL_N-1:0]                  cpl_mis_i,
  input  logic [CPL_N-1:0]                  cpl_exc_i,
  input  logic [RET_N-1:0]                  ret_clr_i,
  input  logic [RET_N-1:0][TAG_W-1:0]       ret_idx_i,
  input  logic                              flush_i,
  input  logic [LOOK_N-1:0][TAG_W-1:0]      look_tag_i,
  output logic [LOOK_N-1:0][DATA_W-1:0]     look_data_o,
  output logic [LOOK_N-1:0]                 look_rdy_o,
  output logic [DEPTH-1:0]                  vld_o,
  output logic [DEPTH-1:0]                  rdy_o,
  output kind_e [DEPTH-1:0]                 kind_o,
  output logic [DEPTH-1:0][REG_AW-1:0]      dst_o,
  output logic [DEPTH-1:0][DATA_W-1:0]      data_o,
  output logic [DEPTH-1:0]                  mis_o,
  output logic [DEPTH-1:0]                  exc_o
);
  logic [DEPTH-1:0]              vld_q, rdy_q, mis_q, exc_q;
  kind_e [DEPTH-1:0]             kind_q;
  logic [DEPTH-1:0][REG_AW-1:0]  dst_q;
  logic [DEPTH-1:0][DATA_W-1:0]  data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      rdy_q  <= '0;
      mis_q  <= '0;
      exc_q  <= '0;
      kind_q <= '{default: KIND_REG};
      dst_q  <= '0;
      data_q <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
      rdy_q <= '0;
    end else begin
      for (int r = 0; r < RET_N; r++)
        if (ret_clr_i[r]) vld_q[ret_idx_i[r]] <= 1'b0;
      // writes to free slots are dropped
      for (int c = 0; c < CPL_N; c++)
        if (cpl_vld_i[c] && vld_q[cpl_tag_i[c]]) begin
          rdy_q[cpl_tag_i[c]]  <= 1'b1;
          data_q[cpl_tag_i[c]] <= cpl_data_i[c];
          mis_q[cpl_tag_i[c]]  <= cpl_mis_i[c];
          exc_q[cpl_tag_i[c]]  <= cpl_exc_i[c];
        end
      for (int a = 0; a < DISP_N; a++)
        if (alloc_we_i[a]) begin
          vld_q[alloc_idx_i[a]]  <= 1'b1;
          rdy_q[alloc_idx_i[a]]  <= 1'b0;
          mis_q[alloc_idx_i[a]]  <= 1'b0;
          exc_q[alloc_idx_i[a]]  <= 1'b0;
          kind_q[alloc_idx_i[a]] <= alloc_kind_i[a];
          dst_q[alloc_idx_i[a]]  <= alloc_dst_i[a];
        end
    end
  end

  for (genvar l = 0; l < LOOK_N; l++) begin : g_look
    assign look_rdy_o[l]  = vld_q[look_tag_i[l]] & rdy_q[look_tag_i[l]];
    assign look_data_o[l] = data_q[look_tag_i[l]];
  end

  for (genvar a = 0; a < DISP_N; a++) begin : g_alloc_chk
    // R2
    alloc_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alloc_we_i[a] |-> !vld_q[alloc_idx_i[a]]);
  end

  for (genvar r = 0; r < RET_N; r++) begin : g_ret_chk
    // R4
    retire_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ret_clr_i[r] |-> (vld_q[ret_idx_i[r]] && rdy_q[ret_idx_i[r]]));
  end

  assign vld_o  = vld_q;
  assign rdy_o  = rdy_q;
  assign kind_o = kind_q;
  assign dst_o  = dst_q;
  assign data_o = data_q;
  assign mis_o  = mis_q;
  assign exc_o  = exc_q;
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RET_N = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [TAG_W-1:0]            head_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [DEPTH-1:0]            vld_i,
  input  logic [DEPTH-1:0]            rdy_i,
  input  kind_e [DEPTH-1:0]           kind_i,
  input  logic [DEPTH-1:0]            mis_i,
  input  logic [DEPTH-1:0]            exc_i,
  output logic [RET_N-1:0]            fire_o,
  output logic [RET_N-1:0][TAG_W-1:0] idx_o,
  output logic                        mis_o,
  output logic                        exc_o,
  output logic [CNT_W-1:0]            ret_n_o
);
  always_comb begin
    logic chain, live, brm;
    logic [TAG_W-1:0] idx;
    chain   = 1'b1;
    mis_o   = 1'b0;
    exc_o   = 1'b0;
    ret_n_o = '0;
    fire_o  = '0;
    for (int k = 0; k < RET_N; k++) begin
      idx      = head_i + TAG_W'(k);
      idx_o[k] = idx;
      live     = chain && (CNT_W'(k) < cnt_i) && vld_i[idx] && rdy_i[idx];
      brm      = (kind_i[idx] == KIND_BRANCH) && mis_i[idx];
      if (k == 0) begin
        // faults and mispredicts act from the head only
        exc_o     = live && exc_i[idx];
        mis_o     = live && !exc_i[idx] && brm;
        fire_o[k] = live && !exc_i[idx];
        chain     = fire_o[k] && !brm;
      end else begin
        fire_o[k] = live && !exc_i[idx] && !brm;
        chain     = fire_o[k];
      end
      ret_n_o = ret_n_o + CNT_W'(fire_o[k]);
    end
  end
endmodule

// File: rtl/rob_commit_unit.sv
module rob_commit_unit
  import rob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int REG_AW = 5,
  parameter int DISP_N = 2,
  parameter int CPL_N  = 2,
  parameter int RET_N  = 2,
  parameter int LOOK_N = 2,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [DISP_N-1:0]          disp_req_i,
  input  logic [DISP_N*2-1:0]        disp_kind_i,
  input  logic [DISP_N*REG_AW-1:0]   disp_dst_i,
  output logic                       disp_ok_o,
  output logic [DISP_N*TAG_W-1:0]    disp_tag_o,
  input  logic [CPL_N-1:0]           cpl_vld_i,
  input  logic [CPL_N*TAG_W-1:0]     cpl_tag_i,
  input  logic [CPL_N*DATA_W-1:0]    cpl_data_i,
  input  logic [CPL_N-1:0]           cpl_mis_i,
  input  logic [CPL_N-1:0]           cpl_exc_i,
  input  logic [LOOK_N*TAG_W-1:0]    look_tag_i,
  output logic [LOOK_N*DATA_W-1:0]   look_data_o,
  output logic [LOOK_N-1:0]          look_rdy_o,
  output logic [RET_N-1:0]           rf_we_o,
  output logic [RET_N-1:0]           st_rel_o,
  output logic [RET_N-1:0]           br_res_o,
  output logic [RET_N*TAG_W-1:0]     ret_tag_o,
  output logic [RET_N*REG_AW-1:0]    ret_dst_o,
  output logic [RET_N*DATA_W-1:0]    ret_data_o,
  output logic                       br_mis_o,
  output logic                       exc_o,
  output logic [TAG_W-1:0]           exc_tag_o
);
  logic [TAG_W-1:0] head, tail;
  logic [CNT_W-1:0] cnt, nreq, alloc_n, ret_n;
  logic             mis_hit, exc_hit, grant;

  logic [DISP_N-1:0][TAG_W-1:0]  a_tag;
  logic [DISP_N-1:0][REG_AW-1:0] a_dst;
  kind_e [DISP_N-1:0]            a_kind;
  logic [DISP_N-1:0]             a_we;
  logic [RET_N-1:0]              fire;
  logic [RET_N-1:0][TAG_W-1:0]   r_idx;
  logic [DEPTH-1:0]              e_vld, e_rdy, e_mis, e_exc;
  kind_e [DEPTH-1:0]             e_kind;
  logic [DEPTH-1:0][REG_AW-1:0]  e_dst;
  logic [DEPTH-1:0][DATA_W-1:0]  e_data;
  logic [LOOK_N-1:0][DATA_W-1:0] l_data;

  for (genvar s = 0; s < DISP_N; s++) begin : g_unpack
    assign a_kind[s] = kind_e'(disp_kind_i[s*2 +: 2]);
  end
  assign a_dst = disp_dst_i;

  always_comb begin
    logic [TAG_W-1:0] off;
    off  = '0;
    nreq = '0;
    for (int s = 0; s < DISP_N; s++) begin
      a_tag[s] = tail + off;
      off      = off + TAG_W'(disp_req_i[s]);
      nreq     = nreq + CNT_W'(disp_req_i[s]);
    end
  end

  // free count taken before this cycle's retirement
  assign grant     = !(mis_hit || exc_hit) && (nreq <= CNT_W'(DEPTH) - cnt);
  assign a_we      = disp_req_i & {DISP_N{grant}};
  assign alloc_n   = grant ? nreq : '0;
  assign disp_ok_o = grant;
  assign disp_tag_o = a_tag;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .alloc_n_i   (alloc_n),
    .ret_n_i     (ret_n),
    .mis_flush_i (mis_hit),
    .exc_flush_i (exc_hit),
    .head_o      (head),
    .tail_o      (tail),
    .cnt_o       (cnt)
  );

  rob_store #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .REG_AW(REG_AW), .DISP_N(DISP_N),
    .CPL_N(CPL_N), .RET_N(RET_N), .LOOK_N(LOOK_N)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_we_i   (a_we),
    .alloc_idx_i  (a_tag),
    .alloc_kind_i (a_kind),
    .alloc_dst_i  (a_dst),
    .cpl_vld_i    (cpl_vld_i),
    .cpl_tag_i    (cpl_tag_i),
    .cpl_data_i   (cpl_data_i),
    .cpl_mis_i    (cpl_mis_i),
    .cpl_exc_i    (cpl_exc_i),
    .ret_clr_i    (fire),
    .ret_idx_i    (r_idx),
    .flush_i      (mis_hit | exc_hit),
    .look_tag_i   (look_tag_i),
    .look_data_o  (l_data),
    .look_rdy_o   (look_rdy_o),
    .vld_o        (e_vld),
    .rdy_o        (e_rdy),
    .kind_o       (e_kind),
    .dst_o        (e_dst),
    .data_o       (e_data),
    .mis_o        (e_mis),
    .exc_o        (e_exc)
  );
  assign look_data_o = l_data;

  rob_retire #(.DEPTH(DEPTH), .RET_N(RET_N)) u_retire (
    .head_i  (head),
    .cnt_i   (cnt),
    .vld_i   (e_vld),
    .rdy_i   (e_rdy),
    .kind_i  (e_kind),
    .mis_i   (e_mis),
    .exc_i   (e_exc),
    .fire_o  (fire),
    .idx_o   (r_idx),
    .mis_o   (mis_hit),
    .exc_o   (exc_hit),
    .ret_n_o (ret_n)
  );

  for (genvar k = 0; k < RET_N; k++) begin : g_ret
    assign rf_we_o[k]  = fire[k] && (e_kind[r_idx[k]] == KIND_REG);
    assign st_rel_o[k] = fire[k] && (e_kind[r_idx[k]] == KIND_STORE);
    assign br_res_o[k] = fire[k] && (e_kind[r_idx[k]] == KIND_BRANCH);
    assign ret_tag_o[k*TAG_W +: TAG_W]    = r_idx[k];
    assign ret_dst_o[k*REG_AW +: REG_AW]  = e_dst[r_idx[k]];
    assign ret_data_o[k*DATA_W +: DATA_W] = e_data[r_idx[k]];
  end

  assign br_mis_o  = mis_hit;
  assign exc_o     = exc_hit;
  assign exc_tag_o = head;

  // R8
  exc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> (rf_we_o == '0) && (st_rel_o == '0) && (br_res_o == '0) && !disp_ok_o);

  // R6
  mis_alone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_mis_o |-> br_res_o[0] && ($countones(rf_we_o | st_rel_o | br_res_o) == 1) && !disp_ok_o);

  // R6
  mis_reopen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_mis_o |=> disp_tag_o[TAG_W-1:0] == $past(ret_tag_o[TAG_W-1:0]) + TAG_W'(1));
endmodule

// File: tb/sim_rob_commit_unit.sv
module sim_rob_commit_unit;
  localparam int D = 16, DW = 32, AW = 5, TW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic [1:0]     disp_req_i;
  logic [3:0]     disp_kind_i;
  logic [2*AW-1:0] disp_dst_i;
  logic           disp_ok_o;
  logic [2*TW-1:0] disp_tag_o;
  logic [1:0]     cpl_vld_i, cpl_mis_i, cpl_exc_i;
  logic [2*TW-1:0] cpl_tag_i;
  logic [2*DW-1:0] cpl_data_i;
  logic [2*TW-1:0] look_tag_i;
  logic [2*DW-1:0] look_data_o;
  logic [1:0]     look_rdy_o, rf_we_o, st_rel_o, br_res_o;
  logic [2*TW-1:0] ret_tag_o;
  logic [2*AW-1:0] ret_dst_o;
  logic [2*DW-1:0] ret_data_o;
  logic           br_mis_o, exc_o;
  logic [TW-1:0]  exc_tag_o;

  rob_commit_unit u0 (.*);

  int checks = 0, bad = 0;
  bit m_vld[D], m_rdy[D], m_mis[D], m_exc[D];
  logic [1:0] m_kind[D];
  logic [AW-1:0] m_dst[D];
  logic [DW-1:0] m_data[D];
  int m_head = 0, m_tail = 0, m_cnt = 0;
  bit e_fire[2];
  bit e_mis, e_exc, e_grant;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clear_in();
    disp_req_i = '0; disp_kind_i = '0; disp_dst_i = '0;
    cpl_vld_i = '0; cpl_mis_i = '0; cpl_exc_i = '0; cpl_tag_i = '0; cpl_data_i = '0;
    look_tag_i = '0;
  endtask

  task automatic eval();
    bit chain, live, brm;
    int idx, nreq;
    chain = 1; e_mis = 0; e_exc = 0;
    for (int k = 0; k < 2; k++) begin
      idx  = (m_head + k) % D;
      live = chain && (k < m_cnt) && m_vld[idx] && m_rdy[idx];
      brm  = (m_kind[idx] == 2'd2) && m_mis[idx];
      if (k == 0) begin
        e_exc = live && m_exc[idx];
        e_mis = live && !m_exc[idx] && brm;
        e_fire[0] = live && !m_exc[idx];
        chain = e_fire[0] && !brm;
      end else begin
        e_fire[1] = live && !m_exc[idx] && !brm;
      end
    end
    nreq = int'(disp_req_i[0]) + int'(disp_req_i[1]);
    e_grant = !(e_mis || e_exc) && (nreq <= D - m_cnt);
  endtask

  task automatic settle();
    int pre, idx, t;
    #1;
    eval();
    chk("R2 disp_ok", disp_ok_o, e_grant);
    if (e_grant) begin
      pre = 0;
      for (int s = 0; s < 2; s++)
        if (disp_req_i[s]) begin
          chk("R2 disp_tag", disp_tag_o[s*TW +: TW], (m_tail + pre) % D);
          pre++;
        end
    end
    for (int k = 0; k < 2; k++) begin
      idx = (m_head + k) % D;
      chk("R4 R5 rf_we", rf_we_o[k], e_fire[k] && m_kind[idx] == 2'd0);
      chk("R4 R5 st_rel", st_rel_o[k], e_fire[k] && m_kind[idx] == 2'd1);
      chk("R4 R5 br_res", br_res_o[k], e_fire[k] && m_kind[idx] == 2'd2);
      if (e_fire[k]) begin
        chk("R4 ret_tag", ret_tag_o[k*TW +: TW], idx);
        chk("R5 ret_data", ret_data_o[k*DW +: DW], m_data[idx]);
        if (m_kind[idx] == 2'd0) chk("R5 ret_dst", ret_dst_o[k*AW +: AW], m_dst[idx]);
      end
    end
    chk("R6 br_mis", br_mis_o, e_mis);
    chk("R8 exc", exc_o, e_exc);
    if (e_exc) chk("R8 exc_tag", exc_tag_o, m_head);
    for (int l = 0; l < 2; l++) begin
      t = int'(look_tag_i[l*TW +: TW]);
      chk("R3 look_rdy", look_rdy_o[l], m_vld[t] && m_rdy[t]);
      if (m_vld[t] && m_rdy[t]) chk("R3 look_data", look_data_o[l*DW +: DW], m_data[t]);
    end
  endtask

  task automatic advance();
    int n, pre, idx, t;
    @(posedge clk_i);
    if (e_exc || e_mis) begin
      for (int i = 0; i < D; i++) begin m_vld[i] = 0; m_rdy[i] = 0; end
      if (e_mis) m_head = (m_head + 1) % D;
      m_tail = m_head;
      m_cnt  = 0;
    end else begin
      n = 0;
      for (int k = 0; k < 2; k++)
        if (e_fire[k]) begin m_vld[(m_head + k) % D] = 0; n++; end
      for (int c = 0; c < 2; c++) begin
        t = int'(cpl_tag_i[c*TW +: TW]);
        if (cpl_vld_i[c] && m_vld[t]) begin
          m_rdy[t] = 1; m_data[t] = cpl_data_i[c*DW +: DW];
          m_mis[t] = cpl_mis_i[c]; m_exc[t] = cpl_exc_i[c];
        end
      end
      if (e_grant) begin
        pre = 0;
        for (int s = 0; s < 2; s++)
          if (disp_req_i[s]) begin
            idx = (m_tail + pre) % D;
            m_vld[idx] = 1; m_rdy[idx] = 0; m_mis[idx] = 0; m_exc[idx] = 0;
            m_kind[idx] = disp_kind_i[s*2 +: 2]; m_dst[idx] = disp_dst_i[s*AW +: AW];
            pre++;
          end
        m_tail = (m_tail + pre) % D;
        m_cnt += pre;
      end
      m_head = (m_head + n) % D;
      m_cnt -= n;
    end
    @(negedge clk_i);
    clear_in();
  endtask

  function automatic int pick_pending(int avoid);
    int st, t;
    st = int'($urandom % D);
    for (int i = 0; i < D; i++) begin
      t = (st + i) % D;
      if (m_vld[t] && !m_rdy[t] && t != avoid) return t;
    end
    return -1;
  endfunction

  task automatic complete(input int port, input int tag, input logic [DW-1:0] val,
                          input bit mis, input bit exc);
    cpl_vld_i[port] = 1'b1;
    cpl_tag_i[port*TW +: TW] = TW'(tag);
    cpl_data_i[port*DW +: DW] = val;
    cpl_mis_i[port] = mis;
    cpl_exc_i[port] = exc;
  endtask

  task automatic drain();
    int t0, t1, guard;
    guard = 0;
    while (m_cnt > 0 && guard < 100) begin
      t0 = pick_pending(-1);
      if (t0 >= 0) complete(0, t0, $urandom, 0, 0);
      t1 = pick_pending(t0);
      if (t1 >= 0) complete(1, t1, $urandom, 0, 0);
      settle();
      advance();
      guard++;
    end
  endtask

  task automatic random_cycle();
    int t0, t1;
    disp_req_i  = 2'($urandom % 4);
    disp_kind_i = {2'($urandom % 3), 2'($urandom % 3)};
    disp_dst_i  = 10'($urandom);
    t0 = -1;
    if ($urandom % 3 != 0) begin
      t0 = pick_pending(-1);
      if (t0 >= 0) complete(0, t0, $urandom, m_kind[t0] == 2'd2 && $urandom % 6 == 0, $urandom % 50 == 0);
    end
    if ($urandom % 3 != 0) begin
      t1 = pick_pending(t0);
      if (t1 >= 0) complete(1, t1, $urandom, m_kind[t1] == 2'd2 && $urandom % 6 == 0, $urandom % 50 == 0);
    end
    look_tag_i = 8'($urandom);
    settle();
    advance();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int hd;
    void'($urandom(32'h1c3b_57a9));
    for (int i = 0; i < D; i++) begin
      m_vld[i] = 0; m_rdy[i] = 0; m_mis[i] = 0; m_exc[i] = 0;
      m_kind[i] = '0; m_dst[i] = '0; m_data[i] = '0;
    end
    clear_in();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    disp_req_i = 2'b11;
    look_tag_i = 8'h53;
    #1;
    chk("R1 disp_ok", disp_ok_o, 1);
    chk("R1 retire idle", {rf_we_o, st_rel_o, br_res_o}, 0);
    chk("R1 flush idle", {br_mis_o, exc_o}, 0);
    chk("R1 look_rdy", look_rdy_o, 0);
    settle();
    advance();
    drain();

    // R10 boundary fill, then R4 out-of-order completion
    for (int i = 0; i < 7; i++) begin
      disp_req_i = 2'b11; disp_kind_i = 4'b0100; disp_dst_i = 10'($urandom);
      settle(); advance();
    end
    disp_req_i = 2'b01; settle(); advance();
    disp_req_i = 2'b11; settle();
    chk("R10 two with one free", disp_ok_o, 0);
    advance();
    disp_req_i = 2'b01; settle();
    chk("R10 one with one free", disp_ok_o, 1);
    advance();
    disp_req_i = 2'b01; settle();
    chk("R2 full refuses", disp_ok_o, 0);
    advance();
    hd = m_head;
    complete(0, (hd + 1) % D, 32'h1111_0001, 0, 0);
    complete(1, (hd + 2) % D, 32'h2222_0002, 0, 0);
    settle(); advance();
    settle();
    chk("R4 younger waits", {rf_we_o, st_rel_o, br_res_o}, 0);
    advance();
    complete(0, hd, 32'h3333_0003, 0, 0);
    settle(); advance();
    settle();
    chk("R4 two retire", rf_we_o | st_rel_o | br_res_o, 2'b11);
    advance();
    drain();

    // R7, R6, R9
    hd = m_head;
    disp_req_i = 2'b11; disp_kind_i = 4'b1000; disp_dst_i = 10'h0A3;
    settle(); advance();
    disp_req_i = 2'b01; disp_kind_i = 4'b0000;
    complete(0, hd, 32'hAAAA_5555, 0, 0);
    complete(1, (hd + 1) % D, 32'h0, 1, 0);
    settle(); advance();
    settle();
    chk("R7 older retires", rf_we_o[0], 1);
    chk("R7 lane1 branch held", br_res_o[1], 0);
    chk("R7 no flush", br_mis_o, 0);
    advance();
    disp_req_i = 2'b01;
    settle();
    chk("R6 flush", br_mis_o, 1);
    chk("R6 branch resolves", br_res_o[0], 1);
    chk("R6 dispatch blocked", disp_ok_o, 0);
    advance();
    complete(0, (hd + 2) % D, 32'hDEAD_BEEF, 0, 0);
    settle(); advance();
    look_tag_i[TW-1:0] = TW'((hd + 2) % D);
    settle();
    chk("R9 discarded stays not ready", look_rdy_o[0], 0);
    advance();
    disp_req_i = 2'b01;
    settle();
    chk("R6 reopen tag", disp_tag_o[TW-1:0], (hd + 2) % D);
    advance();
    drain();

    // R8
    hd = m_head;
    disp_req_i = 2'b11; disp_kind_i = 4'b0000; disp_dst_i = 10'h1FF;
    settle(); advance();
    complete(0, hd, 32'h0BAD_0BAD, 0, 1);
    complete(1, (hd + 1) % D, 32'h600D_600D, 0, 0);
    settle(); advance();
    settle();
    chk("R8 fault taken", exc_o, 1);
    chk("R8 fault tag", exc_tag_o, hd);
    chk("R8 no write", rf_we_o, 0);
    advance();
    disp_req_i = 2'b01;
    settle();
    chk("R8 tag reused", disp_tag_o[TW-1:0], hd);
    advance();
    drain();

    for (int i = 0; i < 4000; i++) random_cycle();
    drain();

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule